// File: doc/BRIEF.md
# Round-Robin Multiphase Peak-Current Phase Controller

This block is the digital heart of the master controller in a multiphase buck converter that runs in peak-current mode with a variable switching frequency. An outside comparator raises `xing_in` each time the error voltage meets the level of the voltage-ramp DAC. Each such crossing switches on one phase. The phases are taken strictly in turn, and the drive for that phase stays high until the phase's own peak-current comparator (`trip_in[i]`) reports that the inductor current has reached its commanded peak. Since the crossings are shared out in a circle over N phases, each phase switches at one N-th of the crossing rate.

The block also outputs the code for the 7-bit peak-current DAC. When slope compensation is off, this code is the programmed peak value. When it is on, the code counts down by one on every clock and stops at zero. It starts again from the programmed value as soon as the comparator of the most recently switched-on phase trips.

Every comparator input arrives asynchronously. Each one passes through a two-flop synchroniser and a rising-edge detector, so an event appears at the outputs three clock edges after its input rises. The block has no data stream, so every pin is a plain level or a pulse with no valid/ready handshake and no back-pressure.

Top module: `rr_phase_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every `phase_drv` bit goes low, `overlap_pulse` goes low, the rotation pointer returns to phase 0, the active phase becomes phase 0 and `idac_code` loads `peak_code`.
- R2: Each rising edge of `xing_in` produces exactly one turn-on event, however long the input stays high. Its effect on `phase_drv` is visible after the third rising clock edge that follows the input change.
- R3: Turn-on events switch on phases 0, 1, …, N-1 in that order and then wrap back to phase 0. Bit i of `phase_drv` drives phase i.
- R4: A phase drive that is high stays high until a rising edge on its own `trip_in` bit, which clears that bit alone, three clock edges later.
- R5: A turn-on event that targets a phase whose drive is already high still advances the pointer and leaves the drives unchanged. It raises `overlap_pulse` for exactly one cycle, in the same cycle in which the turn-on would have appeared.
- R6: With `slope_en` low, `idac_code` equals the value `peak_code` had at the previous clock edge.
- R7: With `slope_en` high and no restart, `idac_code` decreases by one on every clock edge.
- R8: With `slope_en` high, `idac_code` holds at zero once it reaches zero and never wraps around to the top code.
- R9: A rising edge on the `trip_in` bit of the most recently switched-on phase reloads `idac_code` with `peak_code`. A trip on any other phase does not restart the ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| xing_in | input | 1 | Asynchronous crossing comparator (error voltage versus voltage-ramp DAC) |
| trip_in | input | N_PHASES | Asynchronous peak-current comparator of each phase |
| peak_code | input | CODE_W | Programmed peak-current code |
| slope_en | input | 1 | Enables the digital slope-compensation ramp |
| phase_drv | output | N_PHASES | Turn-on drive of each phase |
| idac_code | output | CODE_W | Code for the peak-current DAC |
| overlap_pulse | output | 1 | One-cycle flag raised when a turn-on event hits a phase that is already on |

## Verification
The bench walks the rotation through two full laps and checks the wrap from the last phase to phase 0. It holds the crossing input high for many cycles: a design that detected levels instead of edges would then switch on several phases. It forces turn-on events onto phases that are still on, twice in a row. A design that stalled its pointer on an overlap would aim the next event at the wrong phase, and a design that stretched the flag would show it still high one cycle later. It lets the ramp run down to zero and past it to catch a wrap to 127. It also trips a phase that is not the active one, which must not restart the ramp.

// File: rtl/rr_pc_pkg.sv
package rr_pc_pkg;
  // Width of an index that can address n phases (at least one bit).
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rr_edge_sync.sv
module rr_edge_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] rise
);
  logic [W-1:0] meta_q, stab_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
      prev_q <= stab_q;
    end
  end

  assign rise = stab_q & ~prev_q;
endmodule

// File: rtl/rr_rotor.sv
module rr_rotor
  import rr_pc_pkg::*;
#(
  parameter int unsigned N_PHASES = 4,
  localparam int unsigned PW = idx_w(N_PHASES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ton,
  input  logic [N_PHASES-1:0] trip_rise,
  output logic [N_PHASES-1:0] drv,
  output logic                overlap,
  output logic [PW-1:0]       act_idx
);
  localparam logic [PW-1:0] LAST = PW'(N_PHASES - 1);

  logic [PW-1:0] ptr_q;
  logic [N_PHASES-1:0] sel;

  // One-hot decode of the phase the pointer aims at.
  for (genvar g = 0; g < N_PHASES; g++) begin : g_sel
    assign sel[g] = ton && (ptr_q == PW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      act_idx <= '0;
      overlap <= 1'b0;
    end else begin
      overlap <= ton && ((drv & sel) != '0);
      if (ton) begin
        act_idx <= ptr_q;
        ptr_q   <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  // A turn-on in the same cycle as a trip wins: a new period starts.
  for (genvar g = 0; g < N_PHASES; g++) begin : g_drv
    always_ff @(posedge clk) begin
      if (rst)                drv[g] <= 1'b0;
      else if (sel[g])        drv[g] <= 1'b1;
      else if (trip_rise[g])  drv[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/rr_slope_ramp.sv
module rr_slope_ramp #(
  parameter int unsigned CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slope_en,
  input  logic              restart,
  input  logic [CODE_W-1:0] peak_code,
  output logic [CODE_W-1:0] code
);
  always_ff @(posedge clk) begin
    if (rst || !slope_en || restart) code <= peak_code;
    else if (code != '0)             code <= code - CODE_W'(1);
  end
endmodule

// File: rtl/rr_phase_ctrl.sv
module rr_phase_ctrl
  import rr_pc_pkg::*;
#(
  parameter int unsigned N_PHASES = 4,
  parameter int unsigned CODE_W   = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                xing_in,
  input  logic [N_PHASES-1:0] trip_in,
  input  logic [CODE_W-1:0]   peak_code,
  input  logic                slope_en,
  output logic [N_PHASES-1:0] phase_drv,
  output logic [CODE_W-1:0]   idac_code,
  output logic                overlap_pulse
);
  localparam int unsigned PW = idx_w(N_PHASES);

  logic [N_PHASES:0]   rise_all;
  logic                ton;
  logic [N_PHASES-1:0] trip_rise;
  logic [PW-1:0]       act_idx;
  logic                restart;

  rr_edge_sync #(.W(N_PHASES + 1)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({trip_in, xing_in}),
    .rise     (rise_all)
  );

  assign ton       = rise_all[0];
  assign trip_rise = rise_all[N_PHASES:1];

  rr_rotor #(.N_PHASES(N_PHASES)) u_rotor (
    .clk       (clk),
    .rst       (rst),
    .ton       (ton),
    .trip_rise (trip_rise),
    .drv       (phase_drv),
    .overlap   (overlap_pulse),
    .act_idx   (act_idx)
  );

  assign restart = trip_rise[act_idx];

  rr_slope_ramp #(.CODE_W(CODE_W)) u_ramp (
    .clk       (clk),
    .rst       (rst),
    .slope_en  (slope_en),
    .restart   (restart),
    .peak_code (peak_code),
    .code      (idac_code)
  );
endmodule

// File: rtl/rr_phase_ctrl_chk.sv
module rr_phase_ctrl_chk #(
  parameter int unsigned N_PHASES = 4,
  parameter int unsigned CODE_W   = 7
) (
  input logic                clk,
  input logic                rst,
  input logic                slope_en,
  input logic                restart,
  input logic [CODE_W-1:0]   peak_code,
  input logic [N_PHASES-1:0] phase_drv,
  input logic [CODE_W-1:0]   idac_code,
  input logic                overlap_pulse
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (phase_drv == '0) && !overlap_pulse && (idac_code == $past(peak_code)));

  a_r2_one_phase_on: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $onehot0(phase_drv & ~$past(phase_drv)));

  a_r5_overlap_single: assert property (@(posedge clk) disable iff (rst)
    overlap_pulse |=> !overlap_pulse);

  a_r6_passthru: assert property (@(posedge clk) disable iff (rst)
    !slope_en |=> idac_code == $past(peak_code));

  a_r7_decrement: assert property (@(posedge clk) disable iff (rst)
    (slope_en && !restart && idac_code != '0) |=> idac_code == $past(idac_code) - CODE_W'(1));

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (slope_en && !restart && idac_code == '0) |=> idac_code == '0);

  a_r9_restart_load: assert property (@(posedge clk) disable iff (rst)
    (slope_en && restart) |=> idac_code == $past(peak_code));
endmodule

bind rr_phase_ctrl rr_phase_ctrl_chk #(.N_PHASES(N_PHASES), .CODE_W(CODE_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .slope_en      (slope_en),
  .restart       (restart),
  .peak_code     (peak_code),
  .phase_drv     (phase_drv),
  .idac_code     (idac_code),
  .overlap_pulse (overlap_pulse)
);

// File: tb/rr_phase_ctrl_tb.sv
`timescale 1ns/1ps
module rr_phase_ctrl_tb;
  localparam int N = 4;
  localparam int CW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          xing_in = 1'b0;
  logic [N-1:0]  trip_in = '0;
  logic [CW-1:0] peak_code = 7'd100;
  logic          slope_en = 1'b1;
  logic [N-1:0]  phase_drv;
  logic [CW-1:0] idac_code;
  logic          overlap_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int exp_ptr = 0;
  logic [N-1:0] exp_drv = '0;

  always #10 clk = ~clk;

  rr_phase_ctrl #(.N_PHASES(N), .CODE_W(CW)) u_dut (
    .clk(clk), .rst(rst), .xing_in(xing_in), .trip_in(trip_in),
    .peak_code(peak_code), .slope_en(slope_en), .phase_drv(phase_drv),
    .idac_code(idac_code), .overlap_pulse(overlap_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Raise the crossing input; return at the cycle its effect is visible.
  task automatic xing_rise();
    xing_in = 1'b1;
    wait_neg(3);
  endtask

  task automatic xing_fall();
    xing_in = 1'b0;
    wait_neg(3);
  endtask

  task automatic fire_expect(input int exp_ovl, input string req);
    logic hit;
    hit = exp_drv[exp_ptr];
    exp_drv[exp_ptr] = 1'b1;
    xing_rise();
    chk({req, " drive"}, int'(phase_drv), int'(exp_drv));
    chk({req, " overlap"}, int'(overlap_pulse), exp_ovl);
    if (hit != exp_ovl[0]) chk({req, " bench plan"}, int'(hit), exp_ovl);
    exp_ptr = (exp_ptr + 1) % N;
    wait_neg(1);
    chk("R5 overlap one cycle", int'(overlap_pulse), 0);
    xing_fall();
  endtask

  task automatic trip_clear(input int ph);
    trip_in[ph] = 1'b1;
    wait_neg(3);
    exp_drv[ph] = 1'b0;
    chk("R4 trip clears own phase", int'(phase_drv), int'(exp_drv));
    trip_in[ph] = 1'b0;
    wait_neg(3);
  endtask

  initial begin
    wait_neg(3);
    // R1: reset state
    chk("R1 drives low", int'(phase_drv), 0);
    chk("R1 overlap low", int'(overlap_pulse), 0);
    chk("R1 ramp loaded", int'(idac_code), 100);
    rst = 1'b0;
    slope_en = 1'b0;
    wait_neg(2);

    // R3: two full laps of the rotation, with wrap
    for (int k = 0; k < 2 * N; k++) begin
      int ph;
      ph = exp_ptr;
      fire_expect(0, "R3 rotation");
      trip_clear(ph);
    end

    // R2: long-held crossing gives one event only
    exp_drv[exp_ptr] = 1'b1;
    xing_in = 1'b1;
    wait_neg(12);
    chk("R2 held crossing single phase", int'(phase_drv), int'(exp_drv));
    xing_fall();
    trip_clear(exp_ptr);
    exp_ptr = (exp_ptr + 1) % N;

    // R5: overlaps; pointer keeps advancing (exp_ptr is 1 here)
    for (int k = 0; k < N; k++) fire_expect(0, "R5 fill");
    fire_expect(1, "R5 overlap first");
    fire_expect(1, "R5 overlap pointer advanced");
    trip_clear(3);
    fire_expect(0, "R5 after overlap");
    for (int k = 0; k < N; k++) trip_clear(k);
    // active phase is 3 now

    // R9, R7: restart on the active phase, then decrement
    slope_en = 1'b1;
    trip_in[3] = 1'b1;
    wait_neg(3);
    chk("R9 restart on active trip", int'(idac_code), 100);
    trip_in[3] = 1'b0;
    wait_neg(3);
    chk("R7 decrement per clock", int'(idac_code), 97);
    wait_neg(10);
    chk("R7 decrement per clock", int'(idac_code), 87);
    trip_in[0] = 1'b1;
    wait_neg(3);
    chk("R9 non-active trip no restart", int'(idac_code), 84);
    trip_in[0] = 1'b0;
    wait_neg(3);

    // R8: saturation at zero
    peak_code = 7'd6;
    trip_in[3] = 1'b1;
    wait_neg(3);
    chk("R9 restart with new peak", int'(idac_code), 6);
    trip_in[3] = 1'b0;
    wait_neg(6);
    chk("R8 reaches zero", int'(idac_code), 0);
    wait_neg(20);
    chk("R8 no wrap", int'(idac_code), 0);
    trip_in[3] = 1'b1;
    wait_neg(3);
    chk("R9 restart from zero", int'(idac_code), 6);
    trip_in[3] = 1'b0;

    // R6: pass-through sweep with slope off
    slope_en = 1'b0;
    for (int p = 0; p < 128; p += 9) begin
      peak_code = CW'(p);
      wait_neg(1);
      chk("R6 passthrough", int'(idac_code), p);
    end
    peak_code = 7'd127;
    wait_neg(1);
    chk("R6 passthrough top", int'(idac_code), 127);

    // R1: reset mid-run clears drives
    exp_drv = '0;
    fire_expect(0, "R1 pre-reset");
    rst = 1'b1;
    wait_neg(1);
    chk("R1 reset clears drive", int'(phase_drv), 0);
    rst = 1'b0;
    exp_ptr = 0;
    exp_drv = '0;
    wait_neg(2);
    fire_expect(0, "R1 pointer back to 0");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule